// File: doc/BRIEF.md
# I2C Byte-Transfer Master

This block is the master side of a two-wire I2C bus. It moves exactly one byte per host command. The host works through four byte-wide registers. It puts a byte in the data register and then sets the go bit in the control register. It may set start, stop, NAK or abort in the same write. The block clocks the byte onto or off the bus and runs the acknowledge slot. It then clears go and either holds the bus with SCL low or closes the transfer with a STOP.

A transfer opens with go and start together. The first byte is the target address, and its least significant bit selects direction (1 = read). When a read address is acknowledged, later go-only commands receive bytes. When a write address is acknowledged, or the address is refused, later go-only commands transmit bytes. From the held bus the host has three choices. Setting start with go issues a repeated START and a new address. Setting stop with go ends the transfer after that byte. Setting abort without go ends it with a bare STOP.

Each bit takes four phases (ticks). A tick comes every div+1 clocks, where div is the divider register. SCL is high in phases 1 and 2. SDA is sampled on the tick that ends phase 1. The controller has nine states:
- IDLE: the bus is free.
- START: moves to SEND.
- SEND: moves to RACK after 8 bits.
- RACK: moves to STOP or HOLD.
- RECV: moves to MACK after 8 bits.
- MACK: moves to STOP or HOLD.
- HOLD: moves to RSTART, SEND, RECV or STOP.
- RSTART: moves to SEND.
- STOP: moves back to IDLE.

IDLE leaves only on go with start set. HOLD acts at once on a command.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, SCL is high, SDA is released (sda_oe = 0), irq is low, and the control and status registers read 0.
- R2: Register addresses are 0 = data, 1 = control, 2 = status and 3 = divider. Control bits are 0 go, 1 start, 2 stop, 3 nak, 4 abort and 5 rx_irq_en. Writing go and start while idle produces a START, with SDA falling while SCL is high. The data register byte is then sent, and go clears itself after the acknowledge slot.
- R3: Bytes go out MSB first. While SCL stays high, SDA changes only inside a START, a repeated START or a STOP.
- R4: Status bit 2 holds the SDA level sampled in the most recent acknowledge slot, where 1 means NAK. This applies to both directions.
- R5: After an acknowledged address with bit 0 = 1, a go-only command clocks in 8 bits. The byte is placed in the data register and status bit 0 (receive-full) is set.
- R6: In a received byte's acknowledge slot, the master pulls SDA low when control nak = 0. It leaves SDA released when nak = 1.
- R7: irq is high exactly when receive-full is set and rx_irq_en is set.
- R8: When stop is set with go, a STOP follows the acknowledge slot. Status bit 1 (busy) stays 1 until the STOP completes, and then the stop bit reads 0.
- R9: When start is set with go on a held bus, a repeated START is sent with no STOP before it. It is followed by the data register byte as a new address.
- R10: When abort is set without go on a held bus, only a STOP is produced and no byte is clocked. The abort bit then reads 0.
- R11: Reading the data register clears receive-full. Writing 1 to status bit 0 or bit 2 clears it, and writing 0 leaves it unchanged.
- R12: The divider register reads back as written. The SCL high time of each bit is 2*(div+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data register) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Receive-full interrupt request |
| scl_o | output | 1 | Bus clock level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The bench builds the block with DIV_W = 4 and a reset divider of 5, then writes a divider of 2. Each phase is then three clocks, so a whole byte with its acknowledge slot takes about a hundred clocks. This makes it cheap to run write, read, repeated-start, abort and refused-address transfers back to back against a behavioural slave. The short divider also lets the bench measure the exact SCL high width of 6 clocks.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [1:0] RA_DATA = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_DIV  = 2'd3;

    // control bit positions
    localparam int unsigned CB_GO    = 0;
    localparam int unsigned CB_START = 1;
    localparam int unsigned CB_STOP  = 2;
    localparam int unsigned CB_NAK   = 3;
    localparam int unsigned CB_ABORT = 4;
    localparam int unsigned CB_RXIE  = 5;

    // status bit positions
    localparam int unsigned SB_RXF  = 0;
    localparam int unsigned SB_BUSY = 1;
    localparam int unsigned SB_NAK  = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_SEND,
        S_RACK,
        S_RECV,
        S_MACK,
        S_HOLD,
        S_RSTART,
        S_STOP
    } bm_state_e;

endpackage

// File: rtl/i2c_bm_tick.sv
module i2c_bm_tick #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div != '0)) |=> (!tick || !$stable(div))); // R12

endmodule

// File: rtl/i2c_bm_shift.sv
module i2c_bm_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         in_bit,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], in_bit};
        end
    end

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned DIV_RESET = 49
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_o,
    output logic       sda_oe,
    input  logic       sda_i
);

    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    bm_state_e state_q, state_n;
    logic [1:0]        ph_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              tick, run, slot_end, samp_pt;
    logic              samp_q;
    logic [BYTE_W-1:0] shift_q, data_q;
    logic              sh_load, sh_shift;
    logic              addr_frame_q, rw_pend_q, rd_mode_q;
    logic              go_q, start_q, stop_q, nak_q, abort_q, rxie_q;
    logic              rx_full_q, nak_seen_q;
    logic [DIV_W-1:0]  div_q;
    logic              scl_n, pull_n, cond_q;
    logic              mid;

    // ---------------- phase timing ----------------
    assign run = !(state_q inside {S_IDLE, S_HOLD});

    i2c_bm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (div_q),
        .tick (tick)
    );

    assign slot_end = tick && (ph_q == 2'd3);
    assign samp_pt  = tick && (ph_q == 2'd1);
    assign mid      = (ph_q == 2'd1) || (ph_q == 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= 2'd0;
        end else if (!run) begin
            ph_q <= 2'd0;
        end else if (tick) begin
            ph_q <= ph_q + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= 1'b1;
        end else if (samp_pt) begin
            samp_q <= sda_i;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:   if (go_q && start_q) state_n = S_START;
            S_START,
            S_RSTART: if (slot_end) state_n = S_SEND;
            S_SEND:   if (slot_end && bitcnt_q == LAST_BIT) state_n = S_RACK;
            S_RECV:   if (slot_end && bitcnt_q == LAST_BIT) state_n = S_MACK;
            S_RACK,
            S_MACK:   if (slot_end) state_n = stop_q ? S_STOP : S_HOLD;
            S_HOLD: begin
                if (go_q && start_q)  state_n = S_RSTART;
                else if (go_q)        state_n = rd_mode_q ? S_RECV : S_SEND;
                else if (abort_q)     state_n = S_STOP;
            end
            S_STOP:   if (slot_end) state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
        end else if (state_n != state_q) begin
            bitcnt_q <= '0;
        end else if (slot_end && (state_q == S_SEND || state_q == S_RECV)) begin
            bitcnt_q <= bitcnt_q + 1'b1;
        end
    end

    // ---------------- shift register ----------------
    assign sh_load  = (state_n == S_SEND) && (state_q != S_SEND);
    assign sh_shift = (state_q == S_SEND && slot_end) || (state_q == S_RECV && samp_pt);

    i2c_bm_shift #(.W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .load_val(data_q),
        .shift   (sh_shift),
        .in_bit  (sda_i),
        .q       (shift_q)
    );

    // ---------------- transfer bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_frame_q <= 1'b0;
            rw_pend_q    <= 1'b0;
            rd_mode_q    <= 1'b0;
        end else begin
            if (slot_end && (state_q == S_START || state_q == S_RSTART)) begin
                addr_frame_q <= 1'b1;
                rw_pend_q    <= data_q[0];
            end
            if (slot_end && state_q == S_RACK && addr_frame_q) begin
                addr_frame_q <= 1'b0;
                rd_mode_q    <= rw_pend_q && !samp_q;
            end
            if (slot_end && state_q == S_STOP) begin
                rd_mode_q <= 1'b0;
            end
        end
    end

    // ---------------- host registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= '0;
            go_q       <= 1'b0;
            start_q    <= 1'b0;
            stop_q     <= 1'b0;
            nak_q      <= 1'b0;
            abort_q    <= 1'b0;
            rxie_q     <= 1'b0;
            rx_full_q  <= 1'b0;
            nak_seen_q <= 1'b0;
            div_q      <= DIV_W'(DIV_RESET);
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    RA_DATA: data_q <= reg_wdata;
                    RA_CTRL: begin
                        go_q    <= reg_wdata[CB_GO];
                        start_q <= reg_wdata[CB_START];
                        stop_q  <= reg_wdata[CB_STOP];
                        nak_q   <= reg_wdata[CB_NAK];
                        abort_q <= reg_wdata[CB_ABORT];
                        rxie_q  <= reg_wdata[CB_RXIE];
                    end
                    RA_STAT: begin
                        if (reg_wdata[SB_RXF]) rx_full_q  <= 1'b0;
                        if (reg_wdata[SB_NAK]) nak_seen_q <= 1'b0;
                    end
                    RA_DIV:  div_q <= DIV_W'(reg_wdata);
                    default: ;
                endcase
            end
            if (reg_rd && reg_addr == RA_DATA) rx_full_q <= 1'b0;

            // controller effects take priority over host writes
            if (slot_end && (state_q == S_START || state_q == S_RSTART)) start_q <= 1'b0;
            if (slot_end && (state_q == S_RACK || state_q == S_MACK)) begin
                go_q       <= 1'b0;
                nak_seen_q <= samp_q;
            end
            if (slot_end && state_q == S_MACK) begin
                data_q    <= shift_q;
                rx_full_q <= 1'b1;
            end
            if (state_q == S_IDLE) begin
                if (go_q && !start_q) go_q <= 1'b0;
                if (abort_q)          abort_q <= 1'b0;
            end
            if (state_q == S_HOLD && state_n == S_STOP) abort_q <= 1'b0;
            if (slot_end && state_q == S_STOP) stop_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_DATA: reg_rdata = data_q;
            RA_CTRL: reg_rdata = {2'b00, rxie_q, abort_q, nak_q, stop_q, start_q, go_q};
            RA_STAT: reg_rdata = {5'b00000, nak_seen_q, (state_q != S_IDLE), rx_full_q};
            RA_DIV:  reg_rdata = 8'(div_q);
            default: reg_rdata = '0;
        endcase
    end

    assign irq = rx_full_q && rxie_q;

    // ---------------- bus outputs ----------------
    always_comb begin
        scl_n  = 1'b1;
        pull_n = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_START:  begin scl_n = (ph_q != 2'd3); pull_n = (ph_q != 2'd0); end
            S_RSTART: begin scl_n = mid;            pull_n = ph_q[1];        end
            S_STOP:   begin scl_n = (ph_q != 2'd0); pull_n = !ph_q[1];       end
            S_SEND:   begin scl_n = mid;            pull_n = !shift_q[BYTE_W-1]; end
            S_RACK,
            S_RECV:   scl_n = mid;
            S_MACK:   begin scl_n = mid;            pull_n = !nak_q;         end
            S_HOLD:   scl_n = 1'b0;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_o  <= 1'b1;
            sda_oe <= 1'b0;
            cond_q <= 1'b0;
        end else begin
            scl_o  <= scl_n;
            sda_oe <= pull_n;
            cond_q <= state_q inside {S_START, S_RSTART, S_STOP};
        end
    end

    // ---------------- assertions ----------------
    AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (sda_oe != $past(sda_oe))) |-> cond_q); // R3

    AST_RXFULL_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full_q) |-> ($past(state_q) == S_MACK)); // R5

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && $past(state_q) == S_STOP) |=> (scl_o && !sda_oe)); // R8

    AST_ABORT_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && abort_q && !go_q) |=> (state_q == S_STOP)); // R10

endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq, scl_o, sda_oe, sda_i;
    logic       slv_pull = 1'b0;

    always #5 clk = ~clk;

    assign sda_i = !(sda_oe || slv_pull);

    i2c_byte_master #(.DIV_W(4), .DIV_RESET(5)) i_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard queues
    logic [7:0] exp_q[$];   // bytes the slave should receive
    logic [7:0] tx_q[$];    // bytes the slave returns
    logic       mack_q[$];  // expected master ack-slot level

    // behavioural slave and bus monitor
    logic       scl_p = 1'b1, sda_p = 1'b1;
    bit         active = 0, tx_phase = 0, addr_frame = 0, nak_cfg = 0;
    int         cnt = 0, starts = 0, stops = 0, data_bytes = 0;
    int         hi_cnt = 0, last_hi = 0;
    logic [7:0] sh = 8'd0, txb = 8'hFF;
    logic       mack = 1'b1;

    always @(posedge clk) begin
        logic c, s;
        c = scl_o;
        s = sda_i;
        if (c && !scl_p) hi_cnt = 1;
        else if (c && scl_p) hi_cnt++;
        else if (!c && scl_p) last_hi = hi_cnt;

        if (c && scl_p && sda_p && !s) begin
            starts++; active = 1; cnt = 0; tx_phase = 0; addr_frame = 1;
            slv_pull <= 1'b0;
        end else if (c && scl_p && !sda_p && s) begin
            stops++; active = 0; slv_pull <= 1'b0;
        end else if (active && c && !scl_p) begin
            if (cnt < 8) begin
                if (!tx_phase) sh = {sh[6:0], s};
                cnt++;
            end else if (cnt == 8) begin
                mack = s;
                cnt = 9;
                if (tx_phase) begin
                    if (mack_q.size() > 0) check("R6 master ack level", {31'd0, mack}, {31'd0, mack_q.pop_front()});
                    else check("R6 unexpected ack slot", 32'd1, 32'd0);
                end
            end
        end else if (active && !c && scl_p) begin
            if (cnt == 8) begin
                if (!tx_phase) begin
                    if (!addr_frame) data_bytes++;
                    if (exp_q.size() > 0) check("R3 byte seen on bus", {24'd0, sh}, {24'd0, exp_q.pop_front()});
                    else check("R3 unexpected byte on bus", {24'd0, sh}, 32'hFFFF_FFFF);
                    slv_pull <= !nak_cfg;
                end else begin
                    slv_pull <= 1'b0;
                end
            end else if (cnt == 9) begin
                cnt = 0;
                if (addr_frame) begin
                    tx_phase = sh[0] && !nak_cfg;
                    addr_frame = 0;
                end
                if (tx_phase && !mack) begin
                    txb = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hFF;
                    slv_pull <= !txb[7];
                end else begin
                    tx_phase = 0;
                    slv_pull <= 1'b0;
                end
            end else if (cnt >= 1 && cnt <= 7 && tx_phase) begin
                slv_pull <= !txb[7-cnt];
            end
        end
        scl_p = c;
        sda_p = s;
    end

    // host access tasks
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_go_clear();
        logic [7:0] v;
        v = 8'h01;
        while (v[0]) rd(2'd1, v);
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        v = 8'h02;
        while (v[1]) rd(2'd2, v);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [7:0] ctrl);
        exp_q.push_back(b);
        wr(2'd0, b);
        wr(2'd1, ctrl);
        wait_go_clear();
    endtask

    task automatic recv_byte(input logic [7:0] b, input logic ack_lvl, input logic [7:0] ctrl);
        mack_q.push_back(ack_lvl);
        wr(2'd1, ctrl);
        wait_go_clear();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int s0, p0, d0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 scl high", {31'd0, scl_o}, 32'd1);
        check("R1 sda released", {31'd0, sda_oe}, 32'd0);
        check("R1 irq low", {31'd0, irq}, 32'd0);
        rd(2'd2, v); check("R1 status", {24'd0, v}, 32'd0);
        rd(2'd1, v); check("R1 control", {24'd0, v}, 32'd0);

        // R12 divider
        wr(2'd3, 8'd2);
        rd(2'd3, v); check("R12 divider readback", {24'd0, v}, 32'd2);

        // write transfer: R2, R3, R4, R8
        send_byte(8'hA0, 8'h03);
        check("R2 start seen", starts, 1);
        rd(2'd2, v); check("R4 busy with ack", {24'd0, v}, 32'h02);
        check("R12 scl high width", last_hi, 6);
        send_byte(8'h3C, 8'h01);
        send_byte(8'hC5, 8'h05);
        rd(2'd2, v); check("R8 busy during stop", {31'd0, v[1]}, 32'd1);
        wait_idle();
        check("R8 stop seen", stops, 1);
        check("R8 scl released", {31'd0, scl_o}, 32'd1);
        check("R8 sda released", {31'd0, sda_oe}, 32'd0);
        rd(2'd1, v); check("R8 stop bit cleared", {24'd0, v}, 32'd0);
        check("R3 two data bytes", data_bytes, 2);

        // read transfer with interrupt: R5, R6, R7, R11
        tx_q.push_back(8'h96);
        tx_q.push_back(8'h5A);
        send_byte(8'hA1, 8'h23);
        recv_byte(8'h96, 1'b0, 8'h21);
        check("R7 irq on receive", {31'd0, irq}, 32'd1);
        rd(2'd2, v); check("R5 receive-full set", {24'd0, v}, 32'h03);
        rd(2'd0, v); check("R5 received byte", {24'd0, v}, 32'h96);
        rd(2'd2, v); check("R11 read clears receive-full", {24'd0, v}, 32'h02);
        check("R7 irq dropped", {31'd0, irq}, 32'd0);
        recv_byte(8'h5A, 1'b1, 8'h2D);
        rd(2'd2, v); check("R4 nak recorded", {29'd0, v[2], 1'b0, v[0]}, 32'h5);
        wait_idle();
        rd(2'd0, v); check("R5 last byte", {24'd0, v}, 32'h5A);
        check("R8 second stop", stops, 2);

        // R11 write-one-to-clear
        wr(2'd2, 8'h00);
        rd(2'd2, v); check("R11 write zero keeps", {24'd0, v}, 32'h04);
        wr(2'd2, 8'h04);
        rd(2'd2, v); check("R11 write one clears", {24'd0, v}, 32'h00);

        // repeated start: R9
        s0 = starts; p0 = stops;
        tx_q.push_back(8'h77);
        send_byte(8'hA0, 8'h03);
        send_byte(8'h11, 8'h01);
        send_byte(8'hA1, 8'h03);
        check("R9 repeated start", starts - s0, 2);
        check("R9 no stop between", stops - p0, 0);
        recv_byte(8'h77, 1'b1, 8'h0D);
        check("R7 irq masked", {31'd0, irq}, 32'd0);
        wait_idle();
        rd(2'd0, v); check("R9 read after repeated start", {24'd0, v}, 32'h77);
        check("R9 closing stop", stops - p0, 1);

        // abort: R10
        send_byte(8'hA0, 8'h03);
        d0 = data_bytes; p0 = stops;
        wr(2'd1, 8'h10);
        wait_idle();
        check("R10 no data clocked", data_bytes - d0, 0);
        check("R10 stop only", stops - p0, 1);
        rd(2'd1, v); check("R10 abort cleared", {24'd0, v}, 32'd0);

        // refused address: R4
        nak_cfg = 1;
        send_byte(8'hB0, 8'h03);
        rd(2'd2, v); check("R4 slave nak", {31'd0, v[2]}, 32'd1);
        wr(2'd1, 8'h10);
        wait_idle();
        nak_cfg = 0;

        check("R3 all bytes delivered", exp_q.size(), 0);
        check("R6 all ack slots seen", mack_q.size(), 0);
        finish_run();
    end

endmodule